// File: doc/BRIEF.md
# Supply Reset Pulse Supervisor

This block produces the system reset for a board or a subsystem. It watches a digital flag from a supply comparator, and it watches two reset pins that serve as both input and output. It drives an active-high reset and an active-low reset, each as an open-drain enable. It also raises a lockout flag that blocks memory writes. When the supply drops below its trip level, both resets assert at once. They stay asserted until a fixed number of slow time-base ticks has passed after the supply has recovered.

The two reset pins can be pulled from outside the block. A rising edge on the active-high pin, or a falling edge on the active-low pin, starts a full timeout. A short external reset pulse is therefore stretched into a clean, full-length pulse on both polarities. The block ignores edges on a pin while it is driving that pin itself. A parameter removes the active-high driver for parts that do not bring that pin out; the pin then acts only as an input.

The control is a three-state machine:
- `SUP_HOLD_LOW`: the supply is low.
- `SUP_STRETCH`: the timeout is counting.
- `SUP_RUN`: reset is released.

The transitions are:
- Any state goes to `SUP_HOLD_LOW` when the synchronized supply flag is set (supply drop).
- `SUP_HOLD_LOW` goes to `SUP_STRETCH` when the flag clears (supply recovered). The counter is cleared.
- `SUP_STRETCH` stays in `SUP_STRETCH` on an external edge (restart). The counter is cleared.
- `SUP_STRETCH` goes to `SUP_RUN` on the tick that completes the count (timeout done).
- `SUP_RUN` goes to `SUP_STRETCH` on an external edge (external trigger). The counter is cleared.

After `rst_n`, the machine starts in `SUP_STRETCH`, so power-up gives a full timeout.

Top module: `supply_reset_supervisor`

## Requirements
- R1: After `rst_n` releases, `rst_hi_drv`, `rst_lo_drv` and `wr_lock` are all 1. They fall together in the cycle after the TIMEOUT_TICKS-th `tick` pulse.
- R2: While `supply_low` is 1, `rst_lo_drv` and `wr_lock` are 1, and so is `rst_hi_drv` when HI_PIN_EN=1. They are set no later than SYNC_STAGES+1 cycles after the flag rises, and ticks have no effect while the flag stays set.
- R3: After `supply_low` clears, the resets stay asserted through TIMEOUT_TICKS-1 ticks. They release in the cycle after the TIMEOUT_TICKS-th tick.
- R4: A 0-to-1 transition on `rst_hi_pin` while `rst_hi_drv` is 0 starts a full timeout of TIMEOUT_TICKS ticks.
- R5: A 1-to-0 transition on `rst_lo_pin_n` while `rst_lo_drv` is 0 starts a full timeout of TIMEOUT_TICKS ticks.
- R6: An external pulse a few cycles long, shorter than the timeout, yields resets on both outputs that last the full TIMEOUT_TICKS ticks.
- R7: A pulse on a pin that the block is driving at that moment does not extend the timeout.
- R8: A supply drop during a timeout restarts the count from zero. With HI_PIN_EN=0, a rising edge on `rst_hi_pin` during a timeout also restarts the count from zero.
- R9: With HI_PIN_EN=0, `rst_hi_drv` stays 0 at all times.
- R10: `wr_lock` is 1 exactly when the block holds reset, and it follows `rst_lo_drv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic; treated as power-up |
| tick | input | 1 | One-cycle pulse from the slow time base |
| supply_low | input | 1 | Comparator flag: supply below trip (asynchronous) |
| rst_hi_pin | input | 1 | Sensed level of the active-high reset pin |
| rst_lo_pin_n | input | 1 | Sensed level of the active-low reset pin |
| rst_hi_drv | output | 1 | Enable that drives the active-high pin high |
| rst_lo_drv | output | 1 | Enable that drives the active-low pin low |
| wr_lock | output | 1 | Memory write lockout |

## Verification
The assertions assume that `tick` is a single-cycle pulse synchronous to `clk`. They also assume that each external pin level and the supply flag hold for longer than the synchronizer depth, so every change reaches the state machine. The stimulus applies ticks several cycles apart. It holds every pin pulse and supply pulse for at least three cycles and then lets the synchronizers settle before it sends any tick. The pin levels seen by the block are modelled as wired values: the block's own drive overrides the external level.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
    typedef enum logic [1:0] {
        SUP_HOLD_LOW = 2'd0,
        SUP_STRETCH  = 2'd1,
        SUP_RUN      = 2'd2
    } sup_state_e;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
    parameter bit   ACTIVE_HIGH = 1'b1,
    parameter logic IDLE_LEVEL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic self_drive,
    output logic fire
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= level;
    end

    generate
        if (ACTIVE_HIGH) begin : g_rise
            assign fire = !self_drive && level && !prev_q;
        end else begin : g_fall
            assign fire = !self_drive && !level && prev_q;
        end
    endgenerate
endmodule

// File: rtl/timeout_counter.sv
module timeout_counter #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clear)     cnt_q <= '0;
        else if (tick && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = !clear && tick && (cnt_q == LAST);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor
    import sup_rst_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000,
    parameter bit HI_PIN_EN     = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    input  logic rst_hi_pin,
    input  logic rst_lo_pin_n,
    output logic rst_hi_drv,
    output logic rst_lo_drv,
    output logic wr_lock
);
    sup_state_e state_q, state_d;
    logic sup_s, hi_s, lo_s;
    logic hi_fire, lo_fire, ext_fire;
    logic ctr_clear, ctr_done;
    logic holding;

    level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sup_sync_i (
        .clk(clk), .rst_n(rst_n), .d(supply_low), .q(sup_s));
    level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) hi_sync_i (
        .clk(clk), .rst_n(rst_n), .d(rst_hi_pin), .q(hi_s));
    level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) lo_sync_i (
        .clk(clk), .rst_n(rst_n), .d(rst_lo_pin_n), .q(lo_s));

    pin_edge_detect #(.ACTIVE_HIGH(1'b1), .IDLE_LEVEL(1'b0)) hi_edge_i (
        .clk(clk), .rst_n(rst_n), .level(hi_s), .self_drive(rst_hi_drv), .fire(hi_fire));
    pin_edge_detect #(.ACTIVE_HIGH(1'b0), .IDLE_LEVEL(1'b1)) lo_edge_i (
        .clk(clk), .rst_n(rst_n), .level(lo_s), .self_drive(rst_lo_drv), .fire(lo_fire));

    assign ext_fire = hi_fire || lo_fire;

    timeout_counter #(.TICKS(TIMEOUT_TICKS)) ctr_i (
        .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .tick(tick), .done(ctr_done));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUP_STRETCH;
        else        state_q <= state_d;
    end

    // next state and counter clear
    always_comb begin
        state_d   = state_q;
        ctr_clear = 1'b0;
        unique case (state_q)
            SUP_HOLD_LOW: begin
                ctr_clear = 1'b1;
                if (!sup_s) state_d = SUP_STRETCH;
            end
            SUP_STRETCH: begin
                if (sup_s) begin
                    state_d   = SUP_HOLD_LOW;
                    ctr_clear = 1'b1;
                end else if (ext_fire) begin
                    ctr_clear = 1'b1;
                end else if (ctr_done) begin
                    state_d = SUP_RUN;
                end
            end
            SUP_RUN: begin
                if (sup_s) begin
                    state_d   = SUP_HOLD_LOW;
                    ctr_clear = 1'b1;
                end else if (ext_fire) begin
                    state_d   = SUP_STRETCH;
                    ctr_clear = 1'b1;
                end
            end
            default: begin
                state_d   = SUP_STRETCH;
                ctr_clear = 1'b1;
            end
        endcase
    end

    // outputs
    always_comb begin
        holding    = (state_q != SUP_RUN);
        rst_lo_drv = holding;
        wr_lock    = holding;
    end

    generate
        if (HI_PIN_EN) begin : g_hi_drv
            assign rst_hi_drv = holding;
        end else begin : g_hi_off
            assign rst_hi_drv = 1'b0;
        end
    endgenerate

    // R2
    supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_s |=> wr_lock);

    // R4
    ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fire |=> (wr_lock && rst_lo_drv));

    // R3
    release_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_lock) |-> $past(ctr_done));
endmodule

// File: tb/supply_reset_supervisor_tb.sv
module supply_reset_supervisor_tb_top;
    localparam int N = 8;
    localparam int CYC_LIMIT = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sup = 1'b0;
    logic ext_hi = 1'b0;
    logic ext_lo_n = 1'b1;

    logic hi_drv, lo_drv, lock;
    logic hi_drv2, lo_drv2, lock2;
    logic hi_pin1, lo_pin1, lo_pin2;

    int checks = 0;
    int fails = 0;
    int hi2_bad = 0;

    always #4 clk = ~clk;

    assign hi_pin1 = ext_hi | hi_drv;
    assign lo_pin1 = ext_lo_n & ~lo_drv;
    assign lo_pin2 = ext_lo_n & ~lo_drv2;

    supply_reset_supervisor #(.TIMEOUT_TICKS(N), .HI_PIN_EN(1'b1), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(sup),
        .rst_hi_pin(hi_pin1), .rst_lo_pin_n(lo_pin1),
        .rst_hi_drv(hi_drv), .rst_lo_drv(lo_drv), .wr_lock(lock));

    supply_reset_supervisor #(.TIMEOUT_TICKS(N), .HI_PIN_EN(1'b0), .SYNC_STAGES(2)) dut_nohi_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(sup),
        .rst_hi_pin(ext_hi), .rst_lo_pin_n(lo_pin2),
        .rst_hi_drv(hi_drv2), .rst_lo_drv(lo_drv2), .wr_lock(lock2));

    // R9 monitor: the variant without the high driver must never enable it
    always @(negedge clk) if (rst_n && hi_drv2) hi2_bad++;

    typedef struct packed {
        logic [1:0] act;   // 0 none, 1 high-pin pulse, 2 low-pin pulse, 3 supply pulse
        logic [3:0] nt;    // ticks after the action
        logic       exp;   // expected reset held
        logic [3:0] req;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t ROWS [NROWS] = '{
        '{2'd2, 4'd7, 1'b1, 4'd5},
        '{2'd0, 4'd1, 1'b0, 4'd5},
        '{2'd1, 4'd7, 1'b1, 4'd4},
        '{2'd0, 4'd1, 1'b0, 4'd4},
        '{2'd3, 4'd7, 1'b1, 4'd3},
        '{2'd0, 4'd1, 1'b0, 4'd3},
        '{2'd2, 4'd4, 1'b1, 4'd6},
        '{2'd2, 4'd4, 1'b0, 4'd7},
        '{2'd1, 4'd4, 1'b1, 4'd4},
        '{2'd3, 4'd7, 1'b1, 4'd8},
        '{2'd0, 4'd1, 1'b0, 4'd8}
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got {hi,lo,lock}=%b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_act(input logic [1:0] a);
        if (a == 2'd1) begin
            @(negedge clk) ext_hi = 1'b1;
            repeat (3) @(negedge clk);
            ext_hi = 1'b0;
        end else if (a == 2'd2) begin
            @(negedge clk) ext_lo_n = 1'b0;
            repeat (3) @(negedge clk);
            ext_lo_n = 1'b1;
        end else if (a == 2'd3) begin
            @(negedge clk) sup = 1'b1;
            repeat (4) @(negedge clk);
            sup = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: all held
        check("R1", {hi_drv, lo_drv, lock}, 3'b111);
        give_ticks(N - 1);
        check("R1", {hi_drv, lo_drv, lock}, 3'b111);
        give_ticks(1);
        check("R1", {hi_drv, lo_drv, lock}, 3'b000);

        // R2: held while supply low, ticks ignored
        @(negedge clk) sup = 1'b1;
        repeat (4) @(negedge clk);
        check("R2", {hi_drv, lo_drv, lock}, 3'b111);
        give_ticks(N + 2);
        check("R2", {hi_drv, lo_drv, lock}, 3'b111);
        sup = 1'b0;
        repeat (6) @(negedge clk);
        give_ticks(N - 1);
        check("R3", {hi_drv, lo_drv, lock}, 3'b111);
        give_ticks(1);
        check("R3", {hi_drv, lo_drv, lock}, 3'b000);

        // vector table: both polarities and R10 lock follow the expected hold
        for (int r = 0; r < NROWS; r++) begin
            do_act(ROWS[r].act);
            give_ticks(int'(ROWS[r].nt));
            check(rname(int'(ROWS[r].req)), {hi_drv, lo_drv, lock}, {3{ROWS[r].exp}});
            check("R10", {1'b0, lo_drv2, lock2}, {1'b0, {2{ROWS[r].exp}}});
        end

        // R8: high-pin edge restarts the variant without the high driver
        do_act(2'd2);
        give_ticks(4);
        do_act(2'd1);
        give_ticks(4);
        check("R7", {hi_drv, lo_drv, lock}, 3'b000);
        check("R8", {1'b0, lo_drv2, lock2}, 3'b011);
        give_ticks(3);
        check("R8", {1'b0, lo_drv2, lock2}, 3'b011);
        give_ticks(1);
        check("R8", {1'b0, lo_drv2, lock2}, 3'b000);

        // R9: high driver never enabled in that variant
        checks++;
        if (hi2_bad != 0) begin
            fails++;
            $display("FAIL R9: high drive seen %0d cycles expected 0", hi2_bad);
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (CYC_LIMIT) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule